// File: doc/BRIEF.md
# Masked Vector Elementwise Sequencer

This block runs one unsigned two-operand operation across the elements of a vector register group. It works on a register file stored as 64-bit words that sits outside the block. Each cycle it presents word addresses for the two sources and for the mask register. It reads the returned words in the same cycle and issues at most one byte-enabled word write for the destination element. The sweep covers the body elements from a start index up to, but not including, the active length. Then, if the tail policy asks for it, the sweep covers the tail elements up to the total element count of the group.

For each body element the mask bit and the mask policy decide the outcome. The element is computed, or left untouched (no write), or filled with all ones. Tail elements are filled with ones or left untouched. Element width is 8, 16, 32 or 64 bits. Register grouping is one of 1/8, 1/4, 1/2, 1, 2, 4 or 8 registers. The second operand comes from a source vector or from a scalar truncated to the element width. A start pulse launches a run. A done pulse closes it, and the progress index then reads back as zero.

Top module: `vmask_elem_seq`

## Requirements
- R1: While a run is in progress (busy high), a start pulse has no effect: the writes and completion timing of the current run do not change.
- R2: Elements are handled one per cycle. The k-th element of the sweep (counting from 0, body then tail, including body elements that produce no write) is presented in the k-th cycle after the cycle that accepts start.
- R3: The body begins at element index vstart_i. No element below vstart_i is written. If vstart_i is greater than or equal to vl_i, the body is empty.
- R4: With vm_i = 0, element i is active only when bit i%64 of mask word i/64 is set. The mask register is register 0, so its word address is i/64. With vm_i = 1 every body element is active.
- R5: A masked-off body element is written with all ones in its bytes when vma_i = 1, and is not written at all when vma_i = 0.
- R6: When vta_i = 1, every element from index vl_i up to the total count minus one is written with all ones. When vta_i = 0, no tail element is written.
- R7: vlmul_i is a signed 3-bit code: 000=1, 001=2, 010=4, 011=8, 101=1/8, 110=1/4, 111=1/2 registers. The total element count is (VLEN/8 << max(lmul,0)) >> vsew_i, so a fractional group still spans one full register.
- R8: op_i codes: 0 add, 1 subtract (vs2 minus second operand), 2 AND, 3 OR, 4 XOR, 5 unsigned minimum, 6 unsigned maximum. Code 7 yields zero. Every result is taken modulo the element width. The element width is 8 << vsew_i bits.
- R9: With use_scalar_i = 1, the second operand is scalar_i truncated to the element width and used for every element.
- R10: The write for element i goes to word vd*(VLEN/64) + (i<<vsew_i)/8. Its byte enable has 1<<vsew_i bits set, starting at byte lane (i<<vsew_i)%8. The element value sits at that lane and all other data bytes are zero.
- R11: A vlmul_i of 100 raises illegal_o, which holds until the next accepted start. Such a run makes no write and completes in the first cycle after the start.
- R12: done_o is a single-cycle pulse in the cycle after the last element of the sweep. vstart_o shows the element index during a run and reads zero when done_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Launch pulse, taken only when idle |
| vstart_i | input | IDX_W | First body element index |
| vl_i | input | IDX_W | Active length |
| vsew_i | input | 2 | Element width code, width = 8 << code bits |
| vlmul_i | input | 3 | Register grouping code |
| vm_i | input | 1 | 1 = unmasked, 0 = use mask register |
| vma_i | input | 1 | Masked-off elements filled with ones |
| vta_i | input | 1 | Tail elements filled with ones |
| op_i | input | 3 | Operation code |
| use_scalar_i | input | 1 | Second operand from scalar_i |
| scalar_i | input | 64 | Scalar operand |
| vd_i | input | 5 | Destination register number |
| vs1_i | input | 5 | Second-operand source register |
| vs2_i | input | 5 | First-operand source register |
| src1_addr_o | output | ADDR_W | Word address into vs1 group |
| src1_data_i | input | 64 | Word read from src1_addr_o |
| src2_addr_o | output | ADDR_W | Word address into vs2 group |
| src2_data_i | input | 64 | Word read from src2_addr_o |
| mask_addr_o | output | ADDR_W | Word address into mask register |
| mask_data_i | input | 64 | Word read from mask_addr_o |
| wr_en_o | output | 1 | Destination write strobe |
| wr_addr_o | output | ADDR_W | Destination word address |
| wr_be_o | output | 8 | Byte enables for the write |
| wr_data_o | output | 64 | Write data |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Completion pulse |
| illegal_o | output | 1 | Reserved grouping code seen |
| vstart_o | output | IDX_W | Current element index, zero after completion |

## Verification
Every element has a due cycle. The element at sweep position k shows its write, or shows no write, in the k-th cycle after the accepting edge. The done pulse comes one cycle after the last sweep position, which makes it the first cycle when the run has no elements. The driver works out each expected write, with its sweep position, from the requirements before it raises start. The monitor samples the write port at the falling edge in every cycle. It pops the oldest expected write and compares the address, the byte enables, the data and the cycle count since the accepting edge. A write that appears early, late, extra or missing therefore fails a check.

// File: rtl/vseq_pkg.sv
package vseq_pkg;

    localparam int REG_W     = 5;
    localparam int NUM_VREGS = 32;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_AND  = 3'd2,
        OP_OR   = 3'd3,
        OP_XOR  = 3'd4,
        OP_MINU = 3'd5,
        OP_MAXU = 3'd6,
        OP_NONE = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BODY = 2'd1,
        ST_TAIL = 2'd2,
        ST_DONE = 2'd3
    } phase_e;

    typedef struct packed {
        logic [REG_W-1:0] vd;
        logic [REG_W-1:0] vs1;
        logic [REG_W-1:0] vs2;
        op_e              op;
        logic             use_scalar;
        logic             vm;
        logic             vma;
        logic             vta;
        logic [1:0]       vsew;
        logic [2:0]       vlmul;
        logic [63:0]      scalar;
    } cfg_t;

    // Signed grouping exponent from the 3-bit code.
    function automatic int lmul_exp(input logic [2:0] code);
        return code[2] ? int'(code) - 8 : int'(code);
    endfunction

    function automatic logic grp_reserved(input logic [2:0] code);
        return code == 3'b100;
    endfunction

    // Elements held by the group; a fractional group counts a whole register.
    function automatic logic [15:0] total_elems(input int vlenb,
                                                input logic [1:0] vsew,
                                                input logic [2:0] code);
        int e;
        int t;
        e = lmul_exp(code);
        if (e < 0) e = 0;
        t = (vlenb << e) >> vsew;
        return 16'(t);
    endfunction

    function automatic logic [63:0] width_mask(input logic [1:0] vsew);
        case (vsew)
            2'd0:    return 64'h0000_0000_0000_00FF;
            2'd1:    return 64'h0000_0000_0000_FFFF;
            2'd2:    return 64'h0000_0000_FFFF_FFFF;
            default: return 64'hFFFF_FFFF_FFFF_FFFF;
        endcase
    endfunction

    function automatic logic [7:0] lane_enables(input logic [1:0] vsew);
        case (vsew)
            2'd0:    return 8'h01;
            2'd1:    return 8'h03;
            2'd2:    return 8'h0F;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic logic [63:0] be_to_bits(input logic [7:0] be);
        logic [63:0] r;
        for (int b = 0; b < 8; b++) r[b*8 +: 8] = {8{be[b]}};
        return r;
    endfunction

endpackage

// File: rtl/vseq_alu.sv
module vseq_alu
    import vseq_pkg::*;
(
    input  op_e         op,
    input  logic [1:0]  vsew,
    input  logic [63:0] opa,
    input  logic [63:0] opb,
    output logic [63:0] res
);
    logic [63:0] raw;
    logic [63:0] wm;

    assign wm = width_mask(vsew);

    always_comb begin
        unique case (op)
            OP_ADD:  raw = opa + opb;
            OP_SUB:  raw = opa - opb;
            OP_AND:  raw = opa & opb;
            OP_OR:   raw = opa | opb;
            OP_XOR:  raw = opa ^ opb;
            OP_MINU: raw = (opa < opb) ? opa : opb;
            OP_MAXU: raw = (opa > opb) ? opa : opb;
            default: raw = '0;
        endcase
    end

    assign res = raw & wm;

endmodule

// File: rtl/vseq_addr.sv
module vseq_addr
    import vseq_pkg::*;
#(
    parameter int WPR    = 2,
    parameter int ADDR_W = 6,
    parameter int IDX_W  = 8
) (
    input  logic [IDX_W-1:0]           idx,
    input  logic [1:0]                 vsew,
    input  logic [2:0][REG_W-1:0]      regs,
    output logic [2:0][ADDR_W-1:0]     grp_addr,
    output logic [ADDR_W-1:0]          mask_addr,
    output logic [2:0]                 lane
);
    localparam int WPR_SH = $clog2(WPR);
    localparam int BOFF_W = IDX_W + 3;

    logic [BOFF_W-1:0] boff;
    logic [IDX_W-1:0]  word;

    assign boff = {3'b000, idx} << vsew;
    assign word = boff[BOFF_W-1:3];
    assign lane = boff[2:0];

    // One address per register operand: destination, second, first.
    for (genvar g = 0; g < 3; g++) begin : g_port
        assign grp_addr[g] = (ADDR_W'(regs[g]) << WPR_SH) + ADDR_W'(word);
    end

    assign mask_addr = ADDR_W'(idx >> 6);

endmodule

// File: rtl/vseq_ctrl.sv
module vseq_ctrl
    import vseq_pkg::*;
#(
    parameter int VLENB = 16,
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  cfg_t             cfg_in,
    input  logic [IDX_W-1:0] vstart_in,
    input  logic [IDX_W-1:0] vl_in,
    output cfg_t             cfg_q,
    output phase_e           phase_q,
    output logic [IDX_W-1:0] idx_q,
    output logic             illegal_q,
    output logic             busy,
    output logic             done
);
    logic [IDX_W-1:0] vl_q;
    logic [IDX_W-1:0] total_q;
    logic [IDX_W-1:0] total_in;
    logic             rsv_in;

    assign total_in = IDX_W'(total_elems(VLENB, cfg_in.vsew, cfg_in.vlmul));
    assign rsv_in   = grp_reserved(cfg_in.vlmul);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= ST_IDLE;
            idx_q     <= '0;
            cfg_q     <= '0;
            vl_q      <= '0;
            total_q   <= '0;
            illegal_q <= 1'b0;
        end else begin
            unique case (phase_q)
                ST_IDLE: begin
                    if (start) begin
                        cfg_q     <= cfg_in;
                        vl_q      <= vl_in;
                        total_q   <= total_in;
                        illegal_q <= rsv_in;
                        if (rsv_in) begin
                            phase_q <= ST_DONE;
                            idx_q   <= '0;
                        end else if (vstart_in < vl_in) begin
                            phase_q <= ST_BODY;
                            idx_q   <= vstart_in;
                        end else if (cfg_in.vta && (vl_in < total_in)) begin
                            phase_q <= ST_TAIL;
                            idx_q   <= vl_in;
                        end else begin
                            phase_q <= ST_DONE;
                            idx_q   <= '0;
                        end
                    end
                end
                ST_BODY: begin
                    if (idx_q == vl_q - 1'b1) begin
                        if (cfg_q.vta && (vl_q < total_q)) begin
                            phase_q <= ST_TAIL;
                            idx_q   <= idx_q + 1'b1;
                        end else begin
                            phase_q <= ST_DONE;
                            idx_q   <= '0;
                        end
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                ST_TAIL: begin
                    if (idx_q == total_q - 1'b1) begin
                        phase_q <= ST_DONE;
                        idx_q   <= '0;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                default: begin
                    phase_q <= ST_IDLE;
                    idx_q   <= '0;
                end
            endcase
        end
    end

    assign busy = (phase_q != ST_IDLE);
    assign done = (phase_q == ST_DONE);

    assert_cfg_hold_R1: assert property (@(posedge clk) disable iff (rst)
        (phase_q == ST_BODY || phase_q == ST_TAIL) |=> $stable(cfg_q));

    assert_idx_step_R2: assert property (@(posedge clk) disable iff (rst)
        (phase_q == ST_BODY) |=> (phase_q != ST_BODY || idx_q == $past(idx_q) + 1'b1));

    assert_tail_bound_R6: assert property (@(posedge clk) disable iff (rst)
        (phase_q == ST_TAIL) |-> (idx_q >= vl_q && idx_q < total_q));

    assert_illegal_no_sweep_R11: assert property (@(posedge clk) disable iff (rst)
        illegal_q |-> (phase_q != ST_BODY && phase_q != ST_TAIL));

    assert_done_single_R12: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: rtl/vmask_elem_seq.sv
module vmask_elem_seq
    import vseq_pkg::*;
#(
    parameter int VLEN   = 128,
    parameter int VLENB  = VLEN / 8,
    parameter int WPR    = VLEN / 64,
    parameter int ADDR_W = $clog2(NUM_VREGS * WPR),
    parameter int IDX_W  = $clog2(VLEN + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [IDX_W-1:0]  vstart_i,
    input  logic [IDX_W-1:0]  vl_i,
    input  logic [1:0]        vsew_i,
    input  logic [2:0]        vlmul_i,
    input  logic              vm_i,
    input  logic              vma_i,
    input  logic              vta_i,
    input  logic [2:0]        op_i,
    input  logic              use_scalar_i,
    input  logic [63:0]       scalar_i,
    input  logic [4:0]        vd_i,
    input  logic [4:0]        vs1_i,
    input  logic [4:0]        vs2_i,
    output logic [ADDR_W-1:0] src1_addr_o,
    input  logic [63:0]       src1_data_i,
    output logic [ADDR_W-1:0] src2_addr_o,
    input  logic [63:0]       src2_data_i,
    output logic [ADDR_W-1:0] mask_addr_o,
    input  logic [63:0]       mask_data_i,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [7:0]        wr_be_o,
    output logic [63:0]       wr_data_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              illegal_o,
    output logic [IDX_W-1:0]  vstart_o
);
    cfg_t                     cfg_in;
    cfg_t                     cfg_q;
    phase_e                   phase_q;
    logic [IDX_W-1:0]         idx_q;
    logic [2:0][REG_W-1:0]    regs;
    logic [2:0][ADDR_W-1:0]   gaddr;
    logic [2:0]               lane;
    logic [5:0]               shamt;
    logic [63:0]              wmask;
    logic [63:0]              opa;
    logic [63:0]              opb;
    logic [63:0]              res;
    logic [63:0]              val;
    logic                     active;
    logic                     we;

    always_comb begin
        cfg_in            = '0;
        cfg_in.vd         = vd_i;
        cfg_in.vs1        = vs1_i;
        cfg_in.vs2        = vs2_i;
        cfg_in.op         = op_e'(op_i);
        cfg_in.use_scalar = use_scalar_i;
        cfg_in.vm         = vm_i;
        cfg_in.vma        = vma_i;
        cfg_in.vta        = vta_i;
        cfg_in.vsew       = vsew_i;
        cfg_in.vlmul      = vlmul_i;
        cfg_in.scalar     = scalar_i;
    end

    vseq_ctrl #(.VLENB(VLENB), .IDX_W(IDX_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start_i),
        .cfg_in    (cfg_in),
        .vstart_in (vstart_i),
        .vl_in     (vl_i),
        .cfg_q     (cfg_q),
        .phase_q   (phase_q),
        .idx_q     (idx_q),
        .illegal_q (illegal_o),
        .busy      (busy_o),
        .done      (done_o)
    );

    assign regs[0] = cfg_q.vd;
    assign regs[1] = cfg_q.vs1;
    assign regs[2] = cfg_q.vs2;

    vseq_addr #(.WPR(WPR), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_addr (
        .idx       (idx_q),
        .vsew      (cfg_q.vsew),
        .regs      (regs),
        .grp_addr  (gaddr),
        .mask_addr (mask_addr_o),
        .lane      (lane)
    );

    assign wr_addr_o   = gaddr[0];
    assign src1_addr_o = gaddr[1];
    assign src2_addr_o = gaddr[2];

    assign shamt = {lane, 3'b000};
    assign wmask = width_mask(cfg_q.vsew);
    assign opa   = (src2_data_i >> shamt) & wmask;
    assign opb   = cfg_q.use_scalar ? (cfg_q.scalar & wmask)
                                    : ((src1_data_i >> shamt) & wmask);

    vseq_alu u_alu (
        .op   (cfg_q.op),
        .vsew (cfg_q.vsew),
        .opa  (opa),
        .opb  (opb),
        .res  (res)
    );

    assign active = cfg_q.vm | mask_data_i[idx_q[5:0]];

    always_comb begin
        we  = 1'b0;
        val = '0;
        unique case (phase_q)
            ST_BODY: begin
                if (active) begin
                    we  = 1'b1;
                    val = res;
                end else if (cfg_q.vma) begin
                    we  = 1'b1;
                    val = wmask;
                end
            end
            ST_TAIL: begin
                we  = 1'b1;
                val = wmask;
            end
            default: ;
        endcase
    end

    assign wr_en_o   = we;
    assign wr_data_o = we ? (val << shamt) : '0;
    assign wr_be_o   = we ? (lane_enables(cfg_q.vsew) << lane) : '0;
    assign vstart_o  = idx_q;

    assert_no_write_illegal_R11: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> !wr_en_o);

    assert_be_width_R10: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |-> ($countones(wr_be_o) == (1 << cfg_q.vsew)));

    assert_data_in_lanes_R10: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |-> ((wr_data_o & ~be_to_bits(wr_be_o)) == 64'd0));

    assert_tail_ones_R6: assert property (@(posedge clk) disable iff (rst)
        (phase_q == ST_TAIL) |-> (wr_en_o && ((wr_data_o & be_to_bits(wr_be_o)) == be_to_bits(wr_be_o))));

    assert_masked_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        (phase_q == ST_BODY && !active && !cfg_q.vma) |-> !wr_en_o);

    assert_index_clear_R12: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (vstart_o == '0));

endmodule

// File: tb/vmask_elem_seq_tb_top.sv
module vmask_elem_seq_tb_top;

    localparam int VLEN   = 128;
    localparam int VLENB  = VLEN / 8;
    localparam int WPR    = VLEN / 64;
    localparam int NW     = 32 * WPR;
    localparam int ADDR_W = $clog2(NW);
    localparam int IDX_W  = $clog2(VLEN + 1);
    localparam int VD = 8, VS1 = 16, VS2 = 24;

    typedef struct {
        logic [ADDR_W-1:0] addr;
        logic [7:0]        be;
        logic [63:0]       data;
        int                slot;
        string             req;
    } item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic              start_i = 1'b0;
    logic [IDX_W-1:0]  vstart_i = '0, vl_i = '0;
    logic [1:0]        vsew_i = '0;
    logic [2:0]        vlmul_i = '0, op_i = '0;
    logic              vm_i = 1'b1, vma_i = 1'b0, vta_i = 1'b0, use_scalar_i = 1'b0;
    logic [63:0]       scalar_i = '0;
    logic [4:0]        vd_i = '0, vs1_i = '0, vs2_i = '0;
    logic [ADDR_W-1:0] src1_addr_o, src2_addr_o, mask_addr_o, wr_addr_o;
    logic [63:0]       src1_data_i, src2_data_i, mask_data_i, wr_data_o;
    logic              wr_en_o, busy_o, done_o, illegal_o;
    logic [7:0]        wr_be_o;
    logic [IDX_W-1:0]  vstart_o;

    logic [63:0] rf [0:NW-1];
    item_t       exp_q[$];
    item_t       mon_it;
    int          checks = 0;
    int          errors = 0;
    int          cyc = 0;
    int          base = 0;
    string       cur_req = "R12";

    assign src1_data_i = rf[src1_addr_o];
    assign src2_data_i = rf[src2_addr_o];
    assign mask_data_i = rf[mask_addr_o];

    vmask_elem_seq #(.VLEN(VLEN)) dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .vstart_i(vstart_i), .vl_i(vl_i),
        .vsew_i(vsew_i), .vlmul_i(vlmul_i), .vm_i(vm_i), .vma_i(vma_i), .vta_i(vta_i),
        .op_i(op_i), .use_scalar_i(use_scalar_i), .scalar_i(scalar_i),
        .vd_i(vd_i), .vs1_i(vs1_i), .vs2_i(vs2_i),
        .src1_addr_o(src1_addr_o), .src1_data_i(src1_data_i),
        .src2_addr_o(src2_addr_o), .src2_data_i(src2_data_i),
        .mask_addr_o(mask_addr_o), .mask_data_i(mask_data_i),
        .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_be_o(wr_be_o), .wr_data_o(wr_data_o),
        .busy_o(busy_o), .done_o(done_o), .illegal_o(illegal_o), .vstart_o(vstart_o)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Monitor: compare each write against the oldest expected item.
    always @(negedge clk) begin
        if (!rst && wr_en_o) begin
            if (exp_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL %s: actual write at %h expected none", cur_req, wr_addr_o);
            end else begin
                mon_it = exp_q.pop_front();
                chk("R10", 64'(wr_addr_o), 64'(mon_it.addr));
                chk("R10", 64'(wr_be_o), 64'(mon_it.be));
                chk(mon_it.req, wr_data_o, mon_it.data);
                chk("R2", 64'(cyc - base), 64'(mon_it.slot));
            end
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            if (cyc > 100000) begin
                checks++;
                errors++;
                $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
                finish_run();
            end
        end
    end

    function automatic logic [63:0] wmask_of(input int esz);
        return (esz == 8) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << (esz * 8)) - 64'd1);
    endfunction

    function automatic logic [63:0] rd_elem(input int rg, input int i, input int esz);
        logic [63:0] v = '0;
        for (int b = 0; b < esz; b++) begin
            int ba = rg * VLENB + i * esz + b;
            logic [63:0] by = (rf[ba / 8] >> ((ba % 8) * 8)) & 64'hFF;
            v = v | (by << (8 * b));
        end
        return v;
    endfunction

    function automatic logic [63:0] ref_op(input int op, input logic [63:0] a,
                                           input logic [63:0] b, input logic [63:0] wm);
        logic [63:0] r;
        case (op)
            0: r = a + b;
            1: r = a - b;
            2: r = a & b;
            3: r = a | b;
            4: r = a ^ b;
            5: r = (a < b) ? a : b;
            6: r = (a > b) ? a : b;
            default: r = '0;
        endcase
        return r & wm;
    endfunction

    task automatic push(input int i, input int esz, input logic [63:0] v,
                        input int slot, input string req);
        item_t it;
        int off = i * esz;
        it.addr = ADDR_W'(VD * WPR + off / 8);
        it.be   = 8'(((1 << esz) - 1) << (off % 8));
        it.data = v << ((off % 8) * 8);
        it.slot = slot;
        it.req  = req;
        exp_q.push_back(it);
    endtask

    task automatic run_case(input string req, input string treq, input int vs, input int vl,
                            input int sew, input logic [2:0] lm, input bit vm, input bit vma,
                            input bit vta, input int op, input bit usc, input logic [63:0] sc,
                            input bit poke);
        int esz = 1 << sew;
        int l = lm[2] ? int'(lm) - 8 : int'(lm);
        int emul = (l < 0) ? 0 : l;
        int total = (VLENB << emul) / esz;
        bit rsv = (lm == 3'b100);
        logic [63:0] wm = wmask_of(esz);
        int slot = 0;
        int done_slot;
        bit seen = 0;
        cur_req = req;
        if (!rsv) begin
            for (int i = vs; i < vl; i++) begin
                bit act = vm || rf[i / 64][i % 64];
                if (act) begin
                    logic [63:0] a = rd_elem(VS2, i, esz);
                    logic [63:0] b = usc ? (sc & wm) : rd_elem(VS1, i, esz);
                    push(i, esz, ref_op(op, a, b, wm), slot, req);
                end else if (vma) begin
                    push(i, esz, wm, slot, "R5");
                end
                slot++;
            end
            if (vta) begin
                for (int i = vl; i < total; i++) begin
                    push(i, esz, wm, slot, treq);
                    slot++;
                end
            end
        end
        done_slot = slot;
        @(negedge clk);
        vstart_i = IDX_W'(vs); vl_i = IDX_W'(vl); vsew_i = 2'(sew); vlmul_i = lm;
        vm_i = vm; vma_i = vma; vta_i = vta; op_i = 3'(op); use_scalar_i = usc;
        scalar_i = sc; vd_i = VD; vs1_i = VS1; vs2_i = VS2;
        start_i = 1'b1;
        @(posedge clk);
        #1;
        base = cyc;
        start_i = 1'b0;
        for (int w = 0; w < 400 && !seen; w++) begin
            @(negedge clk);
            if (poke && (cyc - base) == 2) begin
                // R1: a second start mid-run with a different setup
                start_i = 1'b1; vd_i = 5'd3; op_i = 3'd4; vl_i = IDX_W'(7); vstart_i = '0;
            end else begin
                start_i = 1'b0;
            end
            if (done_o) begin
                seen = 1;
                chk("R12", 64'(cyc - base), 64'(done_slot));
                chk("R12", 64'(vstart_o), 64'd0);
                chk("R11", 64'(illegal_o), 64'(rsv));
            end
        end
        if (!seen) chk("R12", 64'd0, 64'd1);
        @(negedge clk);
        chk("R12", 64'(done_o), 64'd0);
        chk("R1", 64'(busy_o), 64'd0);
        chk(req, 64'(exp_q.size()), 64'd0);
        exp_q.delete();
    endtask

    initial begin
        for (int w = 0; w < NW; w++)
            rf[w] = {32'(w) * 32'h9E37_79B9 ^ 32'h5BD1_E995, 32'(w) * 32'h85EB_CA6B + 32'hC2B2_AE35};
        rf[0] = 64'hA5C3_0F96_5A3C_F069;
        rf[1] = 64'h0123_4567_89AB_CDEF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R12", 64'(busy_o), 64'd0);
        chk("R12", 64'(done_o), 64'd0);
        chk("R10", 64'(wr_en_o), 64'd0);
        chk("R12", 64'(vstart_o), 64'd0);
        chk("R11", 64'(illegal_o), 64'd0);

        // R8: add, byte elements, unmasked, tail undisturbed
        run_case("R8", "R6", 0, 16, 0, 3'b000, 1, 0, 0, 0, 0, 64'd0, 0);
        // R4: subtract, halfwords over two registers, mask with agnostic fills
        run_case("R4", "R6", 0, 13, 1, 3'b001, 0, 1, 1, 1, 0, 64'd0, 0);
        // R3: minu from a nonzero start, masked-off left alone
        run_case("R3", "R6", 1, 4, 2, 3'b000, 0, 0, 0, 5, 0, 64'd0, 0);
        // R7: maxu, doublewords, group of four, tail ones
        run_case("R8", "R7", 0, 5, 3, 3'b010, 1, 0, 1, 6, 0, 64'd0, 0);
        // R9: scalar XOR and scalar AND with truncation
        run_case("R9", "R6", 0, 10, 0, 3'b000, 1, 0, 1, 4, 1, 64'hDEAD_BEEF_1234_56AB, 0);
        run_case("R9", "R6", 0, 4, 2, 3'b000, 1, 0, 0, 2, 1, 64'hFFFF_0000_0F0F_F0F0, 0);
        // R8: OR of vectors, halfwords
        run_case("R8", "R6", 0, 8, 1, 3'b000, 1, 0, 0, 3, 0, 64'd0, 0);
        // R7: quarter group still spans one full register
        run_case("R8", "R7", 0, 3, 1, 3'b110, 1, 0, 1, 0, 0, 64'd0, 0);
        // R11: reserved grouping code
        run_case("R11", "R11", 0, 8, 0, 3'b100, 1, 1, 1, 0, 0, 64'd0, 0);
        // R3: start index equal to length leaves only the tail
        run_case("R3", "R6", 5, 5, 0, 3'b000, 1, 0, 1, 0, 0, 64'd0, 0);
        // R4: mask bits from the second mask word, group of eight
        run_case("R4", "R6", 0, 120, 0, 3'b011, 0, 1, 1, 0, 0, 64'd0, 0);
        // R1: start while busy is ignored
        run_case("R1", "R6", 0, 30, 2, 3'b011, 1, 0, 0, 0, 0, 64'd0, 1);

        finish_run();
    end

endmodule